// File: doc/BRIEF.md
# Receive Line Idle Detector

This block watches the receive side of a serial port and raises a sticky idle flag once the line has been quiet for a programmable number of bit times. It can measure quiet in one of two ways. The first is the raw serial input held at logic one. The second is the receiver's state machine resting in its idle state. Time is counted in pulses of a one-cycle bit tick that the baud generator supplies. Once the count goes past an 8-bit threshold, the flag sets.

Software clears the flag by writing a one to it. A separate enable lets the flag drive an interrupt. The flag is armed only once per quiet period. After it fires, it stays quiet until the line has been busy again and then quiet for longer than the threshold. The serial input is asynchronous and passes through a two-stage synchronizer before detection. The receiver's idle indication is taken as already synchronous. The baud generator, the deserializer and the register interface sit outside this block. Plain configuration pins and a clear strobe stand in for them. There is no streaming data path, so every pin is a plain level or strobe.

Top module: `rx_idle_det`

## Requirements
- R1: After reset, `idle_flag` and `irq` are both 0.
- R2: With `cfg_cond_sel` = 0, idle means `rx_in` is high after its two-flop synchronizer, and `rx_sm_idle` has no effect on counting.
- R3: With `cfg_cond_sel` = 1, idle means `rx_sm_idle` is high, and `rx_in` has no effect on counting.
- R4: While the selected condition holds, each `bit_tick` pulse adds one to a bit count. `idle_flag` sets one clock after the count first exceeds `cfg_threshold`, which takes `cfg_threshold`+1 ticks. With exactly `cfg_threshold` ticks the flag stays 0.
- R5: The bit count returns to zero in the cycle after the selected condition goes false. Ticks counted before a busy interval are lost.
- R6: While `cfg_en` is 0, nothing is counted and the flag is never set.
- R7: `irq` is high exactly when `idle_flag` is high and `cfg_irq_en` is 1.
- R8: A cycle with `flag_clr_wr` = 1 and `flag_clr_data` = 1 clears `idle_flag`. A write with `flag_clr_data` = 0 leaves it unchanged. A set event in the same cycle takes priority over the clear.
- R9: After the flag sets, it cannot set again until the selected condition has been false (or `cfg_en` low) for at least one cycle. This holds even if software clears the flag and more idle ticks arrive.
- R10: The bit count saturates at its maximum instead of wrapping. A very long idle period leaves the flag set.
- R11: A tick that arrives in the first two clocks after `rx_in` rises is not counted, because the synchronized line has not yet risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Raw asynchronous serial receive line |
| rx_sm_idle | input | 1 | Receiver state machine is in its idle state (synchronous) |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cfg_en | input | 1 | Detection enable |
| cfg_irq_en | input | 1 | Lets the idle flag drive `irq` |
| cfg_cond_sel | input | 1 | 0: line-high condition, 1: state-machine-idle condition |
| cfg_threshold | input | 8 | Bit-time threshold that the count must exceed |
| flag_clr_wr | input | 1 | Write strobe for the flag bit |
| flag_clr_data | input | 1 | Value written; 1 clears the flag |
| idle_flag | output | 1 | Sticky idle flag |
| irq | output | 1 | Interrupt request |

## Verification
Re-arming is the hardest situation to reach from the ports. The flag must stay low after a clear while the line keeps idling, and then fire again only after a busy interval. The stimulus clears the flag mid-idle, pushes more ticks than the threshold, and only then drops and restores the line. The synchronizer latency is also hard to see. To expose it, the stimulus places a tick in the second clock after the line rises with a threshold of zero. Any shortened synchronizer would count that tick and set the flag.

// File: rtl/rxid_pkg.sv
package rxid_pkg;
  typedef enum logic {
    COND_LINE_HIGH = 1'b0,
    COND_SM_IDLE   = 1'b1
  } idle_cond_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rxid_sync.sv
module rxid_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rxid_bitcnt.sv
module rxid_bitcnt #(
  parameter int unsigned THR_W = 8,
  parameter int unsigned CNT_W = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual,
  input  logic             tick,
  input  logic [THR_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             over
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int unsigned      PAD_W   = CNT_W - THR_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (!qual)                   cnt <= '0;
    else if (tick && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  assign over = cnt > {{PAD_W{1'b0}}, thr};
endmodule

// File: rtl/rxid_flag.sv
module rxid_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  input  logic over,
  input  logic clr,
  output logic set_evt,
  output logic armed,
  output logic flag
);
  assign set_evt = qual & armed & over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b1;
    else if (!qual)   armed <= 1'b1;
    else if (set_evt) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end
endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det
  import rxid_pkg::*;
#(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             rx_sm_idle,
  input  logic             bit_tick,
  input  logic             cfg_en,
  input  logic             cfg_irq_en,
  input  logic             cfg_cond_sel,
  input  logic [THR_W-1:0] cfg_threshold,
  input  logic             flag_clr_wr,
  input  logic             flag_clr_data,
  output logic             idle_flag,
  output logic             irq
);
  localparam int unsigned CNT_W = THR_W + 1;

  logic             rx_s;
  logic             cond;
  logic             qual;
  logic [CNT_W-1:0] cnt_q;
  logic             over;
  logic             set_evt;
  logic             armed_q;
  logic             flag_q;
  logic             clr_req;

  rxid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_in),
    .q     (rx_s)
  );

  assign cond    = (idle_cond_e'(cfg_cond_sel) == COND_SM_IDLE) ? rx_sm_idle : rx_s;
  assign qual    = cfg_en & cond;
  assign clr_req = flag_clr_wr & flag_clr_data;

  rxid_bitcnt #(.THR_W(THR_W), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .qual  (qual),
    .tick  (bit_tick),
    .thr   (cfg_threshold),
    .cnt   (cnt_q),
    .over  (over)
  );

  rxid_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual    (qual),
    .over    (over),
    .clr     (clr_req),
    .set_evt (set_evt),
    .armed   (armed_q),
    .flag    (flag_q)
  );

  assign idle_flag = flag_q;
  assign irq       = flag_q & cfg_irq_en;
endmodule

// File: rtl/rx_idle_det_chk.sv
module rx_idle_det_chk #(
  parameter int unsigned THR_W = 8,
  parameter int unsigned CNT_W = THR_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_irq_en,
  input logic [THR_W-1:0] cfg_threshold,
  input logic             flag_clr_wr,
  input logic             flag_clr_data,
  input logic             idle_flag,
  input logic             irq,
  input logic             qual,
  input logic [CNT_W-1:0] cnt,
  input logic             set_evt,
  input logic             armed
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r4_set_over_thr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> ($past(cnt) > {1'b0, $past(cfg_threshold)}));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (cnt == '0));

  a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (cnt == '0 && !$rose(idle_flag)));

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_wr && flag_clr_data && !set_evt) |=> !idle_flag);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_flag && !(flag_clr_wr && flag_clr_data)) |=> idle_flag);

  a_r9_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> $past(armed));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

bind rx_idle_det rx_idle_det_chk #(.THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en        (cfg_en),
  .cfg_irq_en    (cfg_irq_en),
  .cfg_threshold (cfg_threshold),
  .flag_clr_wr   (flag_clr_wr),
  .flag_clr_data (flag_clr_data),
  .idle_flag     (idle_flag),
  .irq           (irq),
  .qual          (qual),
  .cnt           (cnt_q),
  .set_evt       (set_evt),
  .armed         (armed_q)
);

// File: tb/test_rx_idle_det.sv
module test_rx_idle_det;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       rx_sm_idle = 1'b0;
  logic       bit_tick = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_irq_en = 1'b0;
  logic       cfg_cond_sel = 1'b0;
  logic [7:0] cfg_threshold = 8'd0;
  logic       flag_clr_wr = 1'b0;
  logic       flag_clr_data = 1'b0;
  logic       idle_flag;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rx_idle_det i_rx_idle_det (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_in         (rx_in),
    .rx_sm_idle    (rx_sm_idle),
    .bit_tick      (bit_tick),
    .cfg_en        (cfg_en),
    .cfg_irq_en    (cfg_irq_en),
    .cfg_cond_sel  (cfg_cond_sel),
    .cfg_threshold (cfg_threshold),
    .flag_clr_wr   (flag_clr_wr),
    .flag_clr_data (flag_clr_data),
    .idle_flag     (idle_flag),
    .irq           (irq)
  );

  typedef struct packed {
    logic       sel;
    logic       rxl;
    logic       sm;
    logic [7:0] thr;
    logic [9:0] nt;
    logic       exp;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{1'b0, 1'b1, 1'b0, 8'd3,  10'd3,  1'b0},
    '{1'b0, 1'b1, 1'b0, 8'd3,  10'd4,  1'b1},
    '{1'b0, 1'b0, 1'b1, 8'd0,  10'd5,  1'b0},
    '{1'b1, 1'b0, 1'b1, 8'd2,  10'd3,  1'b1},
    '{1'b1, 1'b1, 1'b0, 8'd0,  10'd4,  1'b0},
    '{1'b1, 1'b0, 1'b1, 8'd0,  10'd1,  1'b1},
    '{1'b0, 1'b1, 1'b1, 8'd0,  10'd0,  1'b0},
    '{1'b0, 1'b1, 1'b0, 8'd10, 10'd11, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic clear_flag(input logic data);
    @(negedge clk) begin flag_clr_wr = 1'b1; flag_clr_data = data; end
    @(negedge clk) begin flag_clr_wr = 1'b0; flag_clr_data = 1'b0; end
  endtask

  task automatic prep(input logic sel, input logic [7:0] thr);
    @(negedge clk) begin
      rx_in = 1'b0; rx_sm_idle = 1'b0; cfg_en = 1'b1;
      cfg_cond_sel = sel; cfg_threshold = thr;
    end
    wait_n(4);
    clear_flag(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R1 flag after reset", idle_flag, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
    rst_n = 1'b1;
    wait_n(2);

    // Table: R2 line condition, R3 state-machine condition, R4 threshold boundary
    for (int i = 0; i < 8; i++) begin
      prep(VT[i].sel, VT[i].thr);
      @(negedge clk) begin rx_in = VT[i].rxl; rx_sm_idle = VT[i].sm; end
      wait_n(4);
      ticks(int'(VT[i].nt));
      wait_n(3);
      chk($sformatf("R2/R3/R4 vector %0d", i), idle_flag, VT[i].exp);
    end

    // R7 interrupt gating (flag is set from the last vector)
    cfg_irq_en = 1'b0;
    wait_n(1);
    chk("R7 irq masked", irq, 1'b0);
    cfg_irq_en = 1'b1;
    wait_n(1);
    chk("R7 irq enabled", irq, 1'b1);

    // R8 write of zero leaves flag set; write of one clears
    clear_flag(1'b0);
    wait_n(2);
    chk("R8 write zero ignored", idle_flag, 1'b1);
    clear_flag(1'b1);
    wait_n(2);
    chk("R8 write one clears", idle_flag, 1'b0);

    // R9 no re-set while idle continues
    ticks(15);
    wait_n(3);
    chk("R9 stays clear without busy interval", idle_flag, 1'b0);
    chk("R9 irq stays low", irq, 1'b0);
    @(negedge clk) rx_in = 1'b0;
    wait_n(4);
    @(negedge clk) rx_in = 1'b1;
    wait_n(4);
    ticks(11);
    wait_n(3);
    chk("R9 re-armed after busy interval", idle_flag, 1'b1);
    cfg_irq_en = 1'b0;

    // R5 restart on busy interval
    prep(1'b0, 8'd5);
    @(negedge clk) rx_in = 1'b1;
    wait_n(4);
    ticks(4);
    @(negedge clk) rx_in = 1'b0;
    wait_n(4);
    @(negedge clk) rx_in = 1'b1;
    wait_n(4);
    ticks(4);
    wait_n(3);
    chk("R5 count restarted", idle_flag, 1'b0);
    ticks(2);
    wait_n(3);
    chk("R5 sets after fresh count", idle_flag, 1'b1);

    // R6 enable low blocks detection
    prep(1'b0, 8'd0);
    @(negedge clk) begin cfg_en = 1'b0; rx_in = 1'b1; end
    wait_n(4);
    ticks(5);
    wait_n(3);
    chk("R6 disabled no flag", idle_flag, 1'b0);
    @(negedge clk) cfg_en = 1'b1;
    ticks(1);
    wait_n(3);
    chk("R6 enabled flag sets", idle_flag, 1'b1);

    // R10 long idle saturates
    prep(1'b0, 8'd255);
    @(negedge clk) rx_in = 1'b1;
    wait_n(4);
    ticks(300);
    wait_n(3);
    chk("R10 set after 256+ ticks", idle_flag, 1'b1);
    ticks(300);
    wait_n(3);
    chk("R10 still set past counter maximum", idle_flag, 1'b1);

    // R11 synchronizer latency: tick in second clock after rise is not counted
    prep(1'b0, 8'd0);
    @(negedge clk) rx_in = 1'b1;
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    wait_n(4);
    chk("R11 early tick ignored", idle_flag, 1'b0);
    ticks(1);
    wait_n(3);
    chk("R11 later tick counted", idle_flag, 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule